// File: doc/BRIEF.md
# Leading Zero and Leading Sign Counter (40-bit)

This block inspects a 40-bit accumulator word and reports two run lengths. The first result is the number of zero bits that precede the first one, counted from the most significant bit downward. The second result is the length of the run of bits that match the most significant bit, with that bit counted. A surrounding accumulator unit feeds the word in and returns the two counts on its read path. That unit uses them to scale or normalise values and to detect headroom before it shifts.

Both counts are 6 bits wide. Each is computed in a single combinational pass as a grouped priority encoder. The sign count reuses the same encoder: the word is first XORed with copies of its own top bit. An optional output register stage, on by default, holds both results. It loads on every clock and resets synchronously to the value that an all-zero word would give.

Top module: `lead_run_count`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registered outputs become `lz_count` = 40 and `ls_count` = 40. This is the result for an all-zero word.
- R2: `lz_count` equals the number of consecutive zero bits of `acc_in`, counted from bit 39 toward bit 0 and stopping at the first one. Its value lies in 0..40.
- R3: `lz_count` is 40 exactly when `acc_in` is all zeros. For every other input it is at most 39.
- R4: When bit 39 of the input is 0, `ls_count` equals `lz_count`. Both count the leading zeros, bit 39 included.
- R5: When bit 39 of the input is 1, `lz_count` is 0. In that case `ls_count` counts the consecutive ones from bit 39 downward, bit 39 included.
- R6: `ls_count` always lies in 1..40. An all-ones input gives `ls_count` = 40 and `lz_count` = 0.
- R7: With the output register on (`OUT_REG` = 1), the results for the input present at a rising edge appear just after that edge. They do not change before it, and they hold while the input holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_in | input | 40 | Accumulator word to inspect |
| lz_count | output | 6 | Number of leading zero bits, 0..40 |
| ls_count | output | 6 | Number of leading bits equal to bit 39, with bit 39 counted, 1..40 |

## Verification
The assertions take the input to be a defined two-state value at each sampling edge. With the register on, they compare each result against the word that was captured one clock earlier. For that reason they wait one cycle after reset is released before they are checked. The stimulus changes `acc_in` only on falling clock edges, so every rising edge sees a stable and fully defined word. The reset check drives a nonzero word, which shows that reset rather than the input sets the outputs.

// File: rtl/lrc_pkg.sv
// Shared sizing helpers for the leading run counter.
// Assumes: all arguments are positive.
package lrc_pkg;

    // Width needed to hold values 0..n inclusive.
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Number of groups of size g needed to cover n bits.
    function automatic int ceil_div(input int n, input int g);
        return (n + g - 1) / g;
    endfunction

endpackage

// File: rtl/lrc_group_enc.sv
// Leading-zero encoder for one small group of bits.
// Produces the number of zeros above the highest set bit and a flag that
// marks an all-zero group. Assumes: GRP_W >= 1. When the group is all
// zeros, the count is don't-care and the merge stage ignores it.
module lrc_group_enc #(
    parameter int GRP_W = 8,
    localparam int GC_W = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
    input  logic [GRP_W-1:0] bits_in,
    output logic [GC_W-1:0]  lead_zeros,
    output logic             all_zero
);

    // Priority scan: the highest set bit wins because it is visited last.
    always_comb begin
        lead_zeros = '0;
        for (int i = 0; i < GRP_W; i++) begin
            if (bits_in[i]) lead_zeros = GC_W'(GRP_W - 1 - i);
        end
    end

    // Group empty flag.
    always_comb all_zero = ~|bits_in;

endmodule

// File: rtl/lrc_scan.sv
// Full-width leading-zero counter built from group encoders.
// Pads the word at the low end up to a whole number of groups, then picks the
// highest non-empty group. The result is clamped to DATA_W so that an all-zero
// word reports exactly DATA_W. Assumes: DATA_W >= 1, GRP_W >= 1.
module lrc_scan #(
    parameter int DATA_W = 40,
    parameter int GRP_W  = 8,
    localparam int CNT_W  = lrc_pkg::cnt_w(DATA_W),
    localparam int NGRP   = lrc_pkg::ceil_div(DATA_W, GRP_W),
    localparam int PAD_W  = NGRP * GRP_W,
    localparam int PCNT_W = lrc_pkg::cnt_w(PAD_W),
    localparam int GC_W   = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [CNT_W-1:0]  zeros_out
);

    logic [PAD_W-1:0]  padded;
    logic [GC_W-1:0]   grp_cnt  [NGRP];
    logic [NGRP-1:0]   grp_zero;
    logic [PCNT_W-1:0] raw_cnt;

    // Left-align the word; filler zeros sit below bit 0.
    generate
        if (PAD_W > DATA_W) begin : g_pad
            always_comb padded = {word_in, {(PAD_W - DATA_W){1'b0}}};
        end else begin : g_nopad
            always_comb padded = word_in;
        end
    endgenerate

    // One encoder per group.
    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            lrc_group_enc #(.GRP_W(GRP_W)) u_enc (
                .bits_in    (padded[g*GRP_W +: GRP_W]),
                .lead_zeros (grp_cnt[g]),
                .all_zero   (grp_zero[g])
            );
        end
    endgenerate

    // Merge: the highest non-empty group sets the count.
    always_comb begin
        raw_cnt = PCNT_W'(PAD_W);
        for (int g = 0; g < NGRP; g++) begin
            if (!grp_zero[g])
                raw_cnt = PCNT_W'((NGRP - 1 - g) * GRP_W) + PCNT_W'(grp_cnt[g]);
        end
    end

    // Clamp padding overshoot back to the true width.
    always_comb begin
        if (raw_cnt > PCNT_W'(DATA_W)) zeros_out = CNT_W'(DATA_W);
        else                           zeros_out = raw_cnt[CNT_W-1:0];
    end

endmodule

// File: rtl/lead_run_count.sv
// Leading zero and leading sign counter for an accumulator word.
// lz_count: zeros above the highest one, 0..DATA_W.
// ls_count: run of bits equal to the MSB with the MSB counted, 1..DATA_W.
// The sign count reuses the zero counter on the word XORed with its MSB.
// With OUT_REG = 1, both results are registered and reset synchronously
// (active low) to DATA_W. With OUT_REG = 0, clk and rst_n are unused.
module lead_run_count #(
    parameter int DATA_W  = 40,
    parameter int GRP_W   = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int CNT_W  = lrc_pkg::cnt_w(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] acc_in,
    output logic [CNT_W-1:0]  lz_count,
    output logic [CNT_W-1:0]  ls_count
);

    logic [DATA_W-1:0] sign_folded;
    logic [CNT_W-1:0]  lz_comb;
    logic [CNT_W-1:0]  ls_comb;

    // Turn the run of sign copies into a run of zeros.
    always_comb sign_folded = acc_in ^ {DATA_W{acc_in[DATA_W-1]}};

    lrc_scan #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_zero_scan (
        .word_in   (acc_in),
        .zeros_out (lz_comb)
    );

    lrc_scan #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_sign_scan (
        .word_in   (sign_folded),
        .zeros_out (ls_comb)
    );

    generate
        if (OUT_REG) begin : g_reg
            // Output register; reset value matches an all-zero word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lz_count <= CNT_W'(DATA_W);
                    ls_count <= CNT_W'(DATA_W);
                end else begin
                    lz_count <= lz_comb;
                    ls_count <= ls_comb;
                end
            end
        end else begin : g_comb
            // Direct combinational outputs.
            always_comb begin
                lz_count = lz_comb;
                ls_count = ls_comb;
            end
        end
    endgenerate

endmodule

// File: rtl/lead_run_count_chk.sv
// Property checker for lead_run_count, attached by bind.
// Keeps its own copy of the input one clock back (when registered) and checks
// the result ranges and the cross relations between the two counts.
module lead_run_count_chk #(
    parameter int DATA_W  = 40,
    parameter bit OUT_REG = 1'b1,
    localparam int CNT_W  = lrc_pkg::cnt_w(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] acc_in,
    input logic [CNT_W-1:0]  lz_count,
    input logic [CNT_W-1:0]  ls_count
);

    logic              primed;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] src;

    // Goes high one cycle after reset release, once outputs reflect an input.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // Input captured alongside the design's output register.
    always_ff @(posedge clk) src_q <= acc_in;

    // Input the current outputs describe.
    always_comb src = OUT_REG ? src_q : acc_in;

    assert_lz_range_R2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        lz_count <= CNT_W'(DATA_W));

    assert_lz_full_R3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (lz_count == CNT_W'(DATA_W)) == (src == '0));

    assert_ls_matches_lz_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        !src[DATA_W-1] |-> (ls_count == lz_count));

    assert_msb_one_lz_zero_R5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        src[DATA_W-1] |-> (lz_count == '0 && ls_count >= CNT_W'(1)));

    assert_ls_range_R6: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ls_count >= CNT_W'(1) && ls_count <= CNT_W'(DATA_W));

endmodule

bind lead_run_count lead_run_count_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_in   (acc_in),
    .lz_count (lz_count),
    .ls_count (ls_count)
);

// File: tb/lead_run_count_tb.sv
// Directed bench for lead_run_count (registered outputs, default widths).
module lead_run_count_tb;

    localparam int W  = 40;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  acc_in = '0;
    logic [CW-1:0] lz_count;
    logic [CW-1:0] ls_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    lead_run_count u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_in   (acc_in),
        .lz_count (lz_count),
        .ls_count (ls_count)
    );

    function automatic int ref_lz(input logic [W-1:0] v);
        int n = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i]) break;
            n++;
        end
        return n;
    endfunction

    function automatic int ref_ls(input logic [W-1:0] v);
        int n = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i] != v[W-1]) break;
            n++;
        end
        return n;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Apply a word, let one rising edge load it, check both counts.
    task automatic apply_check(input logic [W-1:0] v, input string req);
        @(negedge clk) acc_in = v;
        @(negedge clk);
        check(req, "lz_count", int'(lz_count), ref_lz(v));
        check(req, "ls_count", int'(ls_count), ref_ls(v));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk) acc_in = 40'h00_0F00_1234;
        repeat (2) @(negedge clk);
        check("R1", "lz after reset", int'(lz_count), 40);
        check("R1", "ls after reset", int'(ls_count), 40);
        rst_n = 1'b1;
    endtask

    task automatic t_extremes();
        apply_check('0, "R3");
        check("R3", "lz all zero", int'(lz_count), 40);
        apply_check('1, "R6");
        check("R6", "ls all ones", int'(ls_count), 40);
        check("R6", "lz all ones", int'(lz_count), 0);
    endtask

    task automatic t_single_bits();
        for (int k = 0; k < W; k++) begin
            apply_check(W'(1) << k, "R2");
            check("R3", "lz single bit below 40", int'(lz_count < 6'd40), 1);
        end
    endtask

    task automatic t_zero_runs();
        // Positive words: R4 relation across many run lengths.
        for (int k = 1; k < W; k++) begin
            apply_check({W{1'b1}} >> k, "R4");
            check("R4", "ls equals lz", int'(ls_count), int'(lz_count));
        end
    endtask

    task automatic t_one_runs();
        // Negative words: leading ones of length k then a zero.
        for (int k = 1; k < W; k++) begin
            logic [W-1:0] v;
            v = ~({W{1'b1}} >> k);
            v[W-1-k] = 1'b0;
            v[0] = (k < W - 1) ? 1'b1 : 1'b0;
            apply_check(v, "R5");
            check("R5", "lz zero for negative", int'(lz_count), 0);
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 1500; n++) begin
            logic [W-1:0] v;
            int sh;
            v  = {$urandom(), $urandom()};
            sh = $urandom_range(0, W);
            if (n % 2 == 0) v = v >> sh;
            else            v = ~(~v >> sh);
            apply_check(v, (v[W-1]) ? "R5" : "R4");
        end
    endtask

    task automatic t_latency();
        @(negedge clk) acc_in = 40'h00_0000_0001;
        @(negedge clk);
        @(negedge clk) acc_in = 40'h80_0000_0000;
        #1;
        check("R7", "lz before edge", int'(lz_count), 39);
        @(posedge clk); #1;
        check("R7", "lz after edge", int'(lz_count), 0);
        check("R7", "ls after edge", int'(ls_count), 1);
        repeat (3) @(negedge clk);
        check("R7", "lz held", int'(lz_count), 0);
        check("R7", "ls held", int'(ls_count), 1);
    endtask

    task automatic t_reset_mid();
        @(negedge clk) acc_in = 40'hFF_FFFF_0000;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1", "lz mid reset", int'(lz_count), 40);
        check("R1", "ls mid reset", int'(ls_count), 40);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5", "ls after release", int'(ls_count), 24);
    endtask

    initial begin
        t_reset();
        t_extremes();
        t_single_bits();
        t_zero_runs();
        t_one_runs();
        t_random();
        t_latency();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule